// File: doc/BRIEF.md
# Asynchronous Receive Packet Formatter FIFO

This block sits between the receive side of a serial-bus link layer and the host. Each incoming asynchronous packet arrives already parsed: a one-cycle header strobe carries the transaction code, label, retry code, priority, the two node IDs, the response code, the 48-bit offset, the data length, the line speed, the acknowledge code and a status byte. Any payload follows as a stream of quadlets. The block rebuilds the packet into a fixed storage image of 32-bit quadlets and queues it in a FIFO of parameterised depth, 128 quadlets by default.

Every stored packet starts with four quadlets. The first is a token with status, speed and acknowledge code. The second holds the destination ID and the control fields. The third and fourth depend on whether the packet uses the quadlet or the block layout. Payload is stored only for transaction codes that carry data.

The block discards request packets aimed at the local agent and any transaction code it does not handle. A packet that would not fit as a whole is dropped entirely, so the FIFO never holds a partial packet, and a sticky overflow flag is raised. The host empties the queue in order, one quadlet per read strobe, at a single register address.

Top module: `arf_rx_formatter`

## Requirements
- R1: While reset is held, and after it is released, `rdEmpty` is 1 and `rxOverflow` is 0.
- R2: The first quadlet of a stored packet is the token: status in bits 31:24, speed in bits 17:16, ack code in bits 3:0, and zero in all other bits.
- R3: The second quadlet holds, from bit 31 down: destination ID (16 bits), tLabel (6), retry code (2), tCode (4), priority (4).
- R4: tCodes 0h, 2h, 4h and 6h use the quadlet layout. The third quadlet is the source ID in bits 31:16, rCode in bits 15:12 and zero in bits 11:0. The fourth quadlet is all zero.
- R5: tCodes 1h, 5h and 7h use the block layout. The third quadlet is the source ID in bits 31:16 and offset bits 47:32 in bits 15:0. The fourth quadlet is offset bits 31:0.
- R6: After the four header quadlets, tCodes 0h and 6h store exactly one payload quadlet. tCodes 1h and 7h store ceil(length/4) payload quadlets, with the length given in bytes. tCodes 2h, 4h and 5h store none.
- R7: A request (tCode 0h, 1h, 4h or 5h) that arrives with `agentHit` high stores nothing, and its payload is ignored. A response (tCode 2h, 6h or 7h) is stored whatever `agentHit` is.
- R8: A packet whose tCode is 3h or 8h to Fh stores nothing.
- R9: A packet is stored only if the current fill plus its header and payload quadlets is at most DEPTH. Otherwise none of it is stored and `rxOverflow` goes to 1 and stays there until reset. A later packet that fits is still stored.
- R10: A quadlet is removed only when `hostRd` is high, `hostAddr` equals 80h and the FIFO is not empty. `rdData` always shows the oldest quadlet. A read at any other address, or a read while the FIFO is empty, changes nothing.
- R11: Quadlets of consecutive packets come out in arrival order with no gaps between packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktValid | input | 1 | One-cycle header strobe |
| pktTCode | input | 4 | Transaction code |
| pktTLabel | input | 6 | Transaction label |
| pktRetry | input | 2 | Retry code |
| pktPrio | input | 4 | Priority |
| pktDstId | input | 16 | Destination bus/node ID |
| pktSrcId | input | 16 | Source bus/node ID |
| pktRCode | input | 4 | Response code |
| pktOffset | input | 48 | Destination offset |
| pktLen | input | LEN_W | Data length in bytes |
| pktSpeed | input | 2 | Received speed code |
| pktAck | input | 4 | Acknowledge code |
| pktStatus | input | 8 | Receive status byte |
| agentHit | input | 1 | Packet is addressed to the local agent |
| payValid | input | 1 | Payload quadlet strobe |
| payData | input | 32 | Payload quadlet |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host register address |
| rdData | output | 32 | Oldest stored quadlet |
| rdEmpty | output | 1 | FIFO empty |
| rxOverflow | output | 1 | Sticky overflow flag |

## Verification
The assertions rely on the link obeying the input contract. `pktValid` is raised only when the previous packet has finished: four cycles for its header, plus every payload quadlet it owes. Payload strobes come only after those four header cycles, and their number matches what the tCode and length imply, including for packets that end up dropped. Under this contract, a filtered packet's first header cycle shows no write, and an overflow is flagged on a cycle with no write. The bench drives each header for one cycle, waits out the header cycles before sending payload, sends the exact quadlet count even for dropped packets, and leaves idle cycles between packets.

// File: rtl/arf_pkg.sv
package arf_pkg;

  localparam int HDR_QUADS = 4;

  typedef enum logic [2:0] {
    SEL_TOKEN = 3'd0,
    SEL_DEST  = 3'd1,
    SEL_SRC   = 3'd2,
    SEL_LOW   = 3'd3,
    SEL_PAY   = 3'd4
  } quadSel_e;

  typedef struct packed {
    logic     latch;
    logic     push;
    quadSel_e sel;
  } dpCtl_t;

  typedef struct packed {
    logic [7:0]  status;
    logic [1:0]  spd;
    logic [3:0]  ack;
    logic [15:0] dst;
    logic [5:0]  lbl;
    logic [1:0]  rt;
    logic [3:0]  tc;
    logic [3:0]  pri;
    logic [15:0] src;
    logic [3:0]  rcode;
    logic [47:0] off;
  } hdr_t;

  function automatic logic tcQuadData(input logic [3:0] tc);
    return (tc == 4'h0) || (tc == 4'h6);
  endfunction

  function automatic logic tcBlockData(input logic [3:0] tc);
    return (tc == 4'h1) || (tc == 4'h7);
  endfunction

  function automatic logic tcBlockLayout(input logic [3:0] tc);
    return (tc == 4'h1) || (tc == 4'h5) || (tc == 4'h7);
  endfunction

  function automatic logic tcIsRequest(input logic [3:0] tc);
    return (tc == 4'h0) || (tc == 4'h1) || (tc == 4'h4) || (tc == 4'h5);
  endfunction

  function automatic logic tcHandled(input logic [3:0] tc);
    return (tc <= 4'h7) && (tc != 4'h3);
  endfunction

endpackage

// File: rtl/arf_ctrl.sv
module arf_ctrl
  import arf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LEN_W = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktValid,
  input  logic [3:0]       pktTCode,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             agentHit,
  input  logic             payValid,
  input  logic [CNT_W-1:0] fillCount,
  output dpCtl_t           dpCtl,
  output logic             rxOverflow
);

  localparam int PQ_W  = LEN_W;
  localparam int SUM_W = ((PQ_W > CNT_W) ? PQ_W : CNT_W) + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} state_e;

  state_e           state;
  logic [1:0]       hdrIdx;
  logic [PQ_W-1:0]  payLeft;
  logic             keepPkt;

  logic [LEN_W:0]   lenRound;
  logic [PQ_W-1:0]  payQuads;
  logic [SUM_W-1:0] needQuads;
  logic             fitsWhole;
  logic             ruleDrop;

  // Number of payload quadlets the incoming header implies.
  always_comb begin
    lenRound = {1'b0, pktLen} + (LEN_W + 1)'(3);
    if (tcQuadData(pktTCode))       payQuads = PQ_W'(1);
    else if (tcBlockData(pktTCode)) payQuads = PQ_W'(lenRound[LEN_W:2]);
    else                            payQuads = '0;
  end

  assign needQuads = SUM_W'(payQuads) + SUM_W'(HDR_QUADS);
  assign fitsWhole = (SUM_W'(fillCount) + needQuads) <= SUM_W'(DEPTH);
  assign ruleDrop  = !tcHandled(pktTCode) || (tcIsRequest(pktTCode) && agentHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      hdrIdx     <= '0;
      payLeft    <= '0;
      keepPkt    <= 1'b0;
      rxOverflow <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pktValid) begin
            keepPkt <= !ruleDrop && fitsWhole;
            payLeft <= payQuads;
            hdrIdx  <= '0;
            state   <= ST_HDR;
            if (!ruleDrop && !fitsWhole) rxOverflow <= 1'b1;
          end
        end
        ST_HDR: begin
          hdrIdx <= hdrIdx + 2'd1;
          if (hdrIdx == 2'd3) state <= (payLeft != '0) ? ST_PAY : ST_IDLE;
        end
        ST_PAY: begin
          if (payValid) begin
            payLeft <= payLeft - PQ_W'(1);
            if (payLeft == PQ_W'(1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.latch = (state == ST_IDLE) && pktValid;
    dpCtl.push  = keepPkt && ((state == ST_HDR) || ((state == ST_PAY) && payValid));
    dpCtl.sel   = (state == ST_HDR) ? quadSel_e'({1'b0, hdrIdx}) : SEL_PAY;
  end

endmodule

// File: rtl/arf_datapath.sv
module arf_datapath
  import arf_pkg::*;
#(
  parameter int                DEPTH   = 128,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR = 'h80,
  parameter int                CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  hdr_t              hdrIn,
  input  logic [31:0]       payData,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [31:0]       rdData,
  output logic              rdEmpty,
  output logic [CNT_W-1:0]  fillCount
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  hdr_t             hdrQ;
  logic [31:0]      wrWord;
  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             popNow;
  logic             blockLay;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hdrQ <= '0;
    else if (dpCtl.latch) hdrQ <= hdrIn;
  end

  assign blockLay = tcBlockLayout(hdrQ.tc);

  // Build the storage image of the quadlet selected by the control.
  always_comb begin
    unique case (dpCtl.sel)
      SEL_TOKEN: wrWord = {hdrQ.status, 6'd0, hdrQ.spd, 12'd0, hdrQ.ack};
      SEL_DEST:  wrWord = {hdrQ.dst, hdrQ.lbl, hdrQ.rt, hdrQ.tc, hdrQ.pri};
      SEL_SRC:   wrWord = blockLay ? {hdrQ.src, hdrQ.off[47:32]}
                                   : {hdrQ.src, hdrQ.rcode, 12'd0};
      SEL_LOW:   wrWord = blockLay ? hdrQ.off[31:0] : 32'd0;
      default:   wrWord = payData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dpCtl.push) mem[wrPtr] <= wrWord;
  end

  assign rdEmpty = (fillCount == '0);
  assign popNow  = hostRd && (hostAddr == RD_ADDR) && !rdEmpty;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (dpCtl.push) wrPtr <= nextPtr(wrPtr);
      if (popNow)     rdPtr <= nextPtr(rdPtr);
      fillCount <= fillCount + CNT_W'(dpCtl.push) - CNT_W'(popNow);
    end
  end

endmodule

// File: rtl/arf_rx_formatter.sv
module arf_rx_formatter
  import arf_pkg::*;
#(
  parameter int                DEPTH   = 128,
  parameter int                LEN_W   = 16,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [3:0]        pktTCode,
  input  logic [5:0]        pktTLabel,
  input  logic [1:0]        pktRetry,
  input  logic [3:0]        pktPrio,
  input  logic [15:0]       pktDstId,
  input  logic [15:0]       pktSrcId,
  input  logic [3:0]        pktRCode,
  input  logic [47:0]       pktOffset,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic [1:0]        pktSpeed,
  input  logic [3:0]        pktAck,
  input  logic [7:0]        pktStatus,
  input  logic              agentHit,
  input  logic              payValid,
  input  logic [31:0]       payData,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [31:0]       rdData,
  output logic              rdEmpty,
  output logic              rxOverflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dpCtl_t           dpCtl;
  hdr_t             hdrIn;
  logic [CNT_W-1:0] fillCount;
  logic             wrPush;

  assign wrPush = dpCtl.push;

  assign hdrIn = '{status: pktStatus, spd: pktSpeed, ack: pktAck,
                   dst: pktDstId, lbl: pktTLabel, rt: pktRetry,
                   tc: pktTCode, pri: pktPrio, src: pktSrcId,
                   rcode: pktRCode, off: pktOffset};

  arf_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktTCode(pktTCode),
    .pktLen(pktLen), .agentHit(agentHit), .payValid(payValid),
    .fillCount(fillCount), .dpCtl(dpCtl), .rxOverflow(rxOverflow)
  );

  arf_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RD_ADDR(RD_ADDR), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .hdrIn(hdrIn), .payData(payData),
    .hostRd(hostRd), .hostAddr(hostAddr), .rdData(rdData), .rdEmpty(rdEmpty),
    .fillCount(fillCount)
  );

endmodule

// File: rtl/arf_rx_checker.sv
module arf_rx_checker #(
  parameter int                DEPTH   = 128,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR = 'h80,
  parameter int                CNT_W   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pktValid,
  input logic [3:0]        pktTCode,
  input logic              agentHit,
  input logic              hostRd,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              rdEmpty,
  input logic              rxOverflow,
  input logic              push,
  input logic [CNT_W-1:0]  fillCount
);

  p_reset_clears_r1: assert property (@(posedge clk)
    !rstN |=> (rdEmpty && !rxOverflow));

  p_agent_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && agentHit && (pktTCode inside {4'h0, 4'h1, 4'h4, 4'h5})) |=> !push);

  p_odd_tcode_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !(pktTCode inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7})) |=> !push);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  p_push_room_r9: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (fillCount < CNT_W'(DEPTH)));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |=> rxOverflow);

  p_ovf_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverflow) |-> !push);

  p_pop_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && (hostAddr == RD_ADDR) && !rdEmpty && !push)
      |=> (fillCount == $past(fillCount) - CNT_W'(1)));

  p_other_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && (hostAddr != RD_ADDR) && !push) |=> (fillCount == $past(fillCount)));

endmodule

bind arf_rx_formatter arf_rx_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RD_ADDR(RD_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktTCode(pktTCode),
  .agentHit(agentHit), .hostRd(hostRd), .hostAddr(hostAddr), .rdEmpty(rdEmpty),
  .rxOverflow(rxOverflow), .push(wrPush), .fillCount(fillCount)
);

// File: tb/sim_arf_rx_formatter.sv
`timescale 1ns/1ps
module sim_arf_rx_formatter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [3:0]  pktTCode = '0;
  logic [5:0]  pktTLabel = '0;
  logic [1:0]  pktRetry = '0;
  logic [3:0]  pktPrio = '0;
  logic [15:0] pktDstId = '0;
  logic [15:0] pktSrcId = '0;
  logic [3:0]  pktRCode = '0;
  logic [47:0] pktOffset = '0;
  logic [15:0] pktLen = '0;
  logic [1:0]  pktSpeed = '0;
  logic [3:0]  pktAck = '0;
  logic [7:0]  pktStatus = '0;
  logic        agentHit = 1'b0;
  logic        payValid = 1'b0;
  logic [31:0] payData = '0;
  logic        hostRd = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] rdData;
  logic        rdEmpty;
  logic        rxOverflow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  arf_rx_formatter u0 (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktTCode(pktTCode),
    .pktTLabel(pktTLabel), .pktRetry(pktRetry), .pktPrio(pktPrio),
    .pktDstId(pktDstId), .pktSrcId(pktSrcId), .pktRCode(pktRCode),
    .pktOffset(pktOffset), .pktLen(pktLen), .pktSpeed(pktSpeed), .pktAck(pktAck),
    .pktStatus(pktStatus), .agentHit(agentHit), .payValid(payValid),
    .payData(payData), .hostRd(hostRd), .hostAddr(hostAddr), .rdData(rdData),
    .rdEmpty(rdEmpty), .rxOverflow(rxOverflow)
  );

  typedef struct packed {
    logic [3:0]  tc;
    logic        agent;
    logic [15:0] len;
    logic [7:0]  expQ;
  } vec_t;

  // Stimulus and expected quadlet count per packet.
  localparam vec_t VEC [0:10] = '{
    '{tc: 4'h6, agent: 1'b0, len: 16'd4,  expQ: 8'd5},  // R6 quadlet read response
    '{tc: 4'h0, agent: 1'b0, len: 16'd4,  expQ: 8'd5},  // R6 quadlet write request
    '{tc: 4'h1, agent: 1'b0, len: 16'd10, expQ: 8'd7},  // R6 block write, rounded up
    '{tc: 4'h7, agent: 1'b0, len: 16'd8,  expQ: 8'd6},  // R6 block read response
    '{tc: 4'h2, agent: 1'b1, len: 16'd0,  expQ: 8'd4},  // R7 response kept with agentHit
    '{tc: 4'h4, agent: 1'b0, len: 16'd4,  expQ: 8'd4},  // R6 read request, no data
    '{tc: 4'h5, agent: 1'b0, len: 16'd64, expQ: 8'd4},  // R6 block read request
    '{tc: 4'h0, agent: 1'b1, len: 16'd4,  expQ: 8'd0},  // R7 request to agent
    '{tc: 4'h1, agent: 1'b1, len: 16'd12, expQ: 8'd0},  // R7 block request to agent
    '{tc: 4'h3, agent: 1'b0, len: 16'd0,  expQ: 8'd0},  // R8
    '{tc: 4'hA, agent: 1'b0, len: 16'd0,  expQ: 8'd0}   // R8
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int payCount(input logic [3:0] tc, input logic [15:0] len);
    if (tc == 4'h0 || tc == 4'h6) return 1;
    if (tc == 4'h1 || tc == 4'h7) return (int'(len) + 3) / 4;
    return 0;
  endfunction

  function automatic logic [47:0] offOf(input int k);
    return {16'(16'hF000 + k), 32'(32'h1000 + k * 16)};
  endfunction

  function automatic logic [31:0] payOf(input int k, input int i);
    return 32'hD000_0000 + 32'(k * 256 + i);
  endfunction

  function automatic logic [31:0] expWord(input int k, input logic [3:0] tc, input int i);
    logic [47:0] off;
    logic blk;
    off = offOf(k);
    blk = (tc == 4'h1 || tc == 4'h5 || tc == 4'h7);
    case (i)
      0: return {8'(8'h40 + k), 6'd0, 2'(k), 12'd0, 4'(k + 2)};
      1: return {16'(16'hFFC0 + k), 6'(k + 3), 2'(k + 1), tc, 4'(k + 1)};
      2: return blk ? {16'(16'h1230 + k), off[47:32]} : {16'(16'h1230 + k), 4'(k + 5), 12'd0};
      3: return blk ? off[31:0] : 32'd0;
      default: return payOf(k, i - 4);
    endcase
  endfunction

  task automatic sendPkt(input int k, input logic [3:0] tc, input logic ag, input logic [15:0] len);
    int n;
    n = payCount(tc, len);
    pktValid  = 1'b1;
    pktTCode  = tc;
    agentHit  = ag;
    pktLen    = len;
    pktStatus = 8'(8'h40 + k);
    pktSpeed  = 2'(k);
    pktAck    = 4'(k + 2);
    pktDstId  = 16'(16'hFFC0 + k);
    pktTLabel = 6'(k + 3);
    pktRetry  = 2'(k + 1);
    pktPrio   = 4'(k + 1);
    pktSrcId  = 16'(16'h1230 + k);
    pktRCode  = 4'(k + 5);
    pktOffset = offOf(k);
    @(negedge clk);
    pktValid = 1'b0;
    agentHit = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      payValid = 1'b1;
      payData  = payOf(k, i);
      @(negedge clk);
    end
    payValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic string reqOf(input logic [3:0] tc, input int i);
    if (i == 0) return "R2";
    if (i == 1) return "R3";
    if (i < 4) return (tc == 4'h1 || tc == 4'h5 || tc == 4'h7) ? "R5" : "R4";
    return "R6";
  endfunction

  task automatic drainPkt(input int k, input logic [3:0] tc, input int nQ);
    for (int i = 0; i < nQ; i++) begin
      check(!rdEmpty, "R11", 32'(rdEmpty), 32'd0);
      check(rdData == expWord(k, tc, i), reqOf(tc, i), rdData, expWord(k, tc, i));
      hostRd   = 1'b1;
      hostAddr = 8'h80;
      @(negedge clk);
      hostRd = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdEmpty == 1'b1, "R1", 32'(rdEmpty), 32'd1);
    check(rxOverflow == 1'b0, "R1", 32'(rxOverflow), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdEmpty == 1'b1, "R1", 32'(rdEmpty), 32'd1);

    // Table walk: one packet, then drain it.
    for (int v = 0; v < 11; v++) begin
      sendPkt(v, VEC[v].tc, VEC[v].agent, VEC[v].len);
      drainPkt(v, VEC[v].tc, int'(VEC[v].expQ));
      check(rdEmpty == 1'b1, (VEC[v].tc == 4'h3 || VEC[v].tc > 4'h7) ? "R8" :
            (VEC[v].agent ? "R7" : "R6"), 32'(rdEmpty), 32'd1);
    end

    // R11: two packets back to back, drained in order.
    sendPkt(30, 4'h6, 1'b0, 16'd4);
    sendPkt(31, 4'h7, 1'b0, 16'd8);
    drainPkt(30, 4'h6, 5);
    drainPkt(31, 4'h7, 6);
    check(rdEmpty == 1'b1, "R11", 32'(rdEmpty), 32'd1);

    // R10: a read at another address leaves the head in place.
    sendPkt(40, 4'h2, 1'b0, 16'd0);
    hostRd   = 1'b1;
    hostAddr = 8'h7F;
    @(negedge clk);
    hostRd = 1'b0;
    check(rdData == expWord(40, 4'h2, 0), "R10", rdData, expWord(40, 4'h2, 0));
    drainPkt(40, 4'h2, 4);
    // R10: a read while empty changes nothing.
    hostRd   = 1'b1;
    hostAddr = 8'h80;
    @(negedge clk);
    hostRd = 1'b0;
    check(rdEmpty == 1'b1, "R10", 32'(rdEmpty), 32'd1);
    sendPkt(41, 4'h6, 1'b0, 16'd4);
    drainPkt(41, 4'h6, 5);

    // R9: 124 quadlets stored, a 5-quadlet packet does not fit, a 4-quadlet one does.
    check(rxOverflow == 1'b0, "R9", 32'(rxOverflow), 32'd0);
    sendPkt(20, 4'h1, 1'b0, 16'd480);
    sendPkt(21, 4'h6, 1'b0, 16'd4);
    check(rxOverflow == 1'b1, "R9", 32'(rxOverflow), 32'd1);
    sendPkt(22, 4'h2, 1'b0, 16'd0);
    drainPkt(20, 4'h1, 124);
    drainPkt(22, 4'h2, 4);
    check(rdEmpty == 1'b1, "R9", 32'(rdEmpty), 32'd1);
    check(rxOverflow == 1'b1, "R9", 32'(rxOverflow), 32'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule